// File: doc/BRIEF.md
# VBUS Power Switch Supervisor

This block controls an off-chip VBUS power switch for a dual-role USB port. While the port acts as the A-side (the ID input reports A) and software requests bus power without asking for it to be dropped, the block drives the switch enable pin to its active level. It then waits for the switch's status pin to report valid VBUS. The level that counts as active on each pin is chosen by a configuration input, so switches of either polarity can be used.

A rise watchdog counts ticks of a 1 ms strobe while power is ramping. If valid VBUS does not appear within the window (100 ticks by default, a parameter), the block enters a fault state. In that state it releases the enable pin, raises the over-current flag and emits a single-cycle error event. A loss of valid VBUS after power is up leads to the same fault. The fault is held until software pulses the clear input or the port changes to the B-side. A successful power-up emits a single-cycle event of its own.

Top module: `vbus_sup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the enable pin is at its inactive level, the over-current flag is 0 and neither event is raised.
- R2: With `en_pol` = 0 the enable pin is high when the switch is on and low when it is off. With `en_pol` = 1 the pin is low when on and high when off.
- R3: With `st_pol` = 0 a high status pin means VBUS is valid. With `st_pol` = 1 a low status pin means VBUS is valid.
- R4: When `bus_req` = 1, `vbus_drop` = 0 and `id_b` = 0, the enable pin becomes active one clock after these inputs are sampled, and the rise window starts.
- R5: Clearing `bus_req` or setting `vbus_drop` while power is rising or on drives the enable pin inactive one clock later, with no error.
- R6: If the status pin does not report valid VBUS by the `WIN_MS`-th tick after power-up starts, the block faults on that tick's clock. The fault sets `over_cur`, pulses `err_evt` for exactly one cycle and forces the enable pin inactive.
- R7: Valid VBUS during the rise window moves the block to the on state and pulses `up_evt` for one cycle. If valid VBUS arrives in the same cycle as the final tick of the window, success wins and no fault is raised.
- R8: The status pin is ignored while the switch is not being driven. A valid status with power off raises no event and does not change the enable pin.
- R9: The fault holds, regardless of `bus_req` and of the status pin, until `err_clr` is pulsed. That pulse returns the block to off. If the request is still present, a new power-up starts one clock later.
- R10: Losing valid VBUS while on faults the block, with one `err_evt` pulse and `over_cur` set.
- R11: `id_b` = 1 returns the block to off on the next clock from any state, including the fault, and restarts the rise window from zero on the next attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pol | input | 1 | Enable pin polarity: 0 active high, 1 active low |
| st_pol | input | 1 | Status pin polarity: 0 active high, 1 active low |
| bus_req | input | 1 | Software request for bus power |
| vbus_drop | input | 1 | Software request to drop bus power |
| id_b | input | 1 | Port role: 1 = B-side, 0 = A-side |
| vbus_st_pin | input | 1 | Raw status pin from the power switch |
| err_clr | input | 1 | Single-cycle pulse that clears the fault |
| tick_ms | input | 1 | Single-cycle strobe once per millisecond |
| vbus_en_pin | output | 1 | Registered enable pin to the power switch |
| over_cur | output | 1 | Fault flag, held until cleared |
| err_evt | output | 1 | Single-cycle pulse on entry to the fault |
| up_evt | output | 1 | Single-cycle pulse when VBUS becomes valid |

## Verification
The two functions that can coincide are the arrival of valid VBUS and the expiry of the rise window. The bench provokes this by issuing one tick fewer than the window allows, then raising the final tick and the valid status in the same cycle. The outcome is judged against a behavioural reference model that is compared every clock: `up_evt` must pulse while `err_evt` and `over_cur` stay low. Fault entry, clearing and the B-side override are also interleaved with an active request, so that the fault is shown to outrank the request and the role change to outrank the fault.

// File: rtl/vbus_sup_pkg.sv
package vbus_sup_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_RISE  = 2'd1,
    PS_ON    = 2'd2,
    PS_FAULT = 2'd3
  } psw_state_t;
endpackage

// File: rtl/vbus_rise_timer.sv
module vbus_rise_timer #(
  parameter int WIN_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(WIN_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_MS - 1);

  logic [CW-1:0] cnt;

  // counter restarts whenever the rise phase is not active
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign expire = run && tick && (cnt == LAST);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST)); // R6
endmodule

// File: rtl/vbus_pin_drv.sv
module vbus_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic en_pol,
  input  logic st_pol,
  input  logic drive_nxt,
  input  logic st_pin,
  output logic en_pin,
  output logic st_active
);
  // status in true-high sense
  assign st_active = st_pin ^ st_pol;

  always_ff @(posedge clk) begin
    if (rst) en_pin <= en_pol;
    else     en_pin <= drive_nxt ^ en_pol;
  end
endmodule

// File: rtl/vbus_sup_fsm.sv
module vbus_sup_fsm
  import vbus_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       want,
  input  logic       st_active,
  input  logic       id_b,
  input  logic       err_clr,
  input  logic       expire,
  output psw_state_t state,
  output logic       drive_nxt,
  output logic       fault_q,
  output logic       err_evt_q,
  output logic       up_evt_q
);
  psw_state_t nxt;
  logic       vld;

  // status only counts while the switch is being driven
  assign vld = st_active && (state == PS_RISE || state == PS_ON);

  always_comb begin
    nxt = state;
    if (id_b) begin
      nxt = PS_OFF;
    end else begin
      case (state)
        PS_OFF:   if (want) nxt = PS_RISE;
        PS_RISE: begin
          if (!want)       nxt = PS_OFF;
          else if (vld)    nxt = PS_ON;
          else if (expire) nxt = PS_FAULT;
        end
        PS_ON: begin
          if (!want)       nxt = PS_OFF;
          else if (!vld)   nxt = PS_FAULT;
        end
        PS_FAULT: if (err_clr) nxt = PS_OFF;
        default:  nxt = PS_OFF;
      endcase
    end
  end

  assign drive_nxt = (nxt == PS_RISE) || (nxt == PS_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_OFF;
      fault_q   <= 1'b0;
      err_evt_q <= 1'b0;
      up_evt_q  <= 1'b0;
    end else begin
      state     <= nxt;
      fault_q   <= (nxt == PS_FAULT);
      err_evt_q <= (nxt == PS_FAULT) && (state != PS_FAULT);
      up_evt_q  <= (nxt == PS_ON) && (state == PS_RISE);
    end
  end

  AST_ERR_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    err_evt_q |=> !err_evt_q); // R6
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(up_evt_q && err_evt_q)); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(fault_q) && !$past(err_clr) && !$past(id_b)) |-> fault_q); // R9
  AST_B_SIDE_OFF: assert property (@(posedge clk) disable iff (rst)
    id_b |=> (state == PS_OFF)); // R11
  AST_REQ_START: assert property (@(posedge clk) disable iff (rst)
    (state == PS_OFF && want) |=> (state == PS_RISE)); // R4
endmodule

// File: rtl/vbus_sup.sv
module vbus_sup
  import vbus_sup_pkg::*;
#(
  parameter int WIN_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en_pol,
  input  logic st_pol,
  input  logic bus_req,
  input  logic vbus_drop,
  input  logic id_b,
  input  logic vbus_st_pin,
  input  logic err_clr,
  input  logic tick_ms,
  output logic vbus_en_pin,
  output logic over_cur,
  output logic err_evt,
  output logic up_evt
);
  psw_state_t state;
  logic want, st_active, expire, drive_nxt;

  assign want = bus_req && !vbus_drop && !id_b;

  vbus_pin_drv u_pin (
    .clk(clk), .rst(rst), .en_pol(en_pol), .st_pol(st_pol),
    .drive_nxt(drive_nxt), .st_pin(vbus_st_pin),
    .en_pin(vbus_en_pin), .st_active(st_active)
  );

  vbus_rise_timer #(.WIN_MS(WIN_MS)) u_tmr (
    .clk(clk), .rst(rst), .run(state == PS_RISE),
    .tick(tick_ms), .expire(expire)
  );

  vbus_sup_fsm u_fsm (
    .clk(clk), .rst(rst), .want(want), .st_active(st_active),
    .id_b(id_b), .err_clr(err_clr), .expire(expire),
    .state(state), .drive_nxt(drive_nxt), .fault_q(over_cur),
    .err_evt_q(err_evt), .up_evt_q(up_evt)
  );

  AST_FAULT_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    over_cur |-> (vbus_en_pin == en_pol)); // R6
  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    vbus_drop |=> (vbus_en_pin == $past(en_pol))); // R5
endmodule

// File: tb/vbus_sup_tb_top.sv
module vbus_sup_tb_top;
  localparam int WIN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_pol = 1'b0, st_pol = 1'b0, bus_req = 1'b0, vbus_drop = 1'b0;
  logic id_b = 1'b0, vbus_st_pin = 1'b0, err_clr = 1'b0, tick_ms = 1'b0;
  logic vbus_en_pin, over_cur, err_evt, up_evt;

  int checks = 0;
  int fails = 0;
  int n_err = 0;
  int n_up = 0;
  string tag = "R1";
  bit started = 0;
  bit done = 0;

  // reference model state: 0 off, 1 rising, 2 on, 3 fault
  int m_st = 0;
  int m_cnt = 0;
  logic m_pin = 1'b0, m_oc = 1'b0, m_err = 1'b0, m_up = 1'b0;

  always #10 clk = ~clk;

  vbus_sup #(.WIN_MS(WIN)) dut_i (
    .clk(clk), .rst(rst), .en_pol(en_pol), .st_pol(st_pol),
    .bus_req(bus_req), .vbus_drop(vbus_drop), .id_b(id_b),
    .vbus_st_pin(vbus_st_pin), .err_clr(err_clr), .tick_ms(tick_ms),
    .vbus_en_pin(vbus_en_pin), .over_cur(over_cur),
    .err_evt(err_evt), .up_evt(up_evt)
  );

  always @(posedge clk) begin
    bit want, v;
    want = bus_req && !vbus_drop && !id_b;
    v = (vbus_st_pin != st_pol);
    m_err = 1'b0;
    m_up = 1'b0;
    started = 1;
    if (rst) begin
      m_st = 0; m_cnt = 0;
    end else if (id_b) begin
      m_st = 0; m_cnt = 0;
    end else if (m_st == 0) begin
      if (want) begin m_st = 1; m_cnt = 0; end
    end else if (m_st == 1) begin
      if (!want) begin m_st = 0; m_cnt = 0; end
      else if (v) begin m_st = 2; m_up = 1'b1; m_cnt = 0; end
      else if (tick_ms) begin
        if (m_cnt == WIN - 1) begin m_st = 3; m_err = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
    end else if (m_st == 2) begin
      if (!want) m_st = 0;
      else if (!v) begin m_st = 3; m_err = 1'b1; end
    end else begin
      if (err_clr) m_st = 0;
    end
    m_pin = ((m_st == 1 || m_st == 2) ? 1'b1 : 1'b0) ^ en_pol;
    m_oc = (m_st == 3);
  end

  task automatic chk(input string r, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(tag, vbus_en_pin, m_pin, "model vbus_en_pin");
      chk(tag, over_cur, m_oc, "model over_cur");
      chk(tag, err_evt, m_err, "model err_evt");
      chk(tag, up_evt, m_up, "model up_evt");
      if (err_evt === 1'b1) n_err++;
      if (up_evt === 1'b1) n_up++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; idle(1);
      tick_ms = 1'b0; idle(1);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    tag = "R1";
    chk("R1", vbus_en_pin, 1'b0, "pin in reset");
    chk("R1", over_cur, 1'b0, "over_cur in reset");
    rst = 1'b0; idle(1);
    chk("R1", vbus_en_pin, 1'b0, "pin after reset");
    chk("R1", err_evt, 1'b0, "no event after reset");
    idle(1);

    tag = "R8";
    vbus_st_pin = 1'b1; idle(4);
    chk("R8", vbus_en_pin, 1'b0, "pin stays off with valid status");
    chk("R8", n_up != 0, 1'b0, "no up_evt while off");
    vbus_st_pin = 1'b0;

    tag = "R4";
    bus_req = 1'b1; idle(1);
    chk("R4", vbus_en_pin, 1'b1, "pin active after request");
    idle(2);
    chk("R4", over_cur, 1'b0, "no fault while rising");

    tag = "R7";
    vbus_st_pin = 1'b1; idle(1);
    chk("R7", up_evt, 1'b1, "up_evt on valid");
    idle(1);
    chk("R7", up_evt, 1'b0, "up_evt single cycle");
    chk("R7", vbus_en_pin, 1'b1, "pin held on");

    tag = "R10";
    vbus_st_pin = 1'b0; idle(1);
    chk("R10", err_evt, 1'b1, "err_evt on loss");
    chk("R10", over_cur, 1'b1, "over_cur on loss");
    chk("R10", vbus_en_pin, 1'b0, "pin released in fault");
    idle(1);
    chk("R10", err_evt, 1'b0, "err_evt once");

    tag = "R9";
    vbus_st_pin = 1'b1; idle(10);
    chk("R9", over_cur, 1'b1, "fault held with request");
    chk("R9", vbus_en_pin, 1'b0, "pin off while held");
    err_clr = 1'b1; idle(1);
    err_clr = 1'b0;
    chk("R9", over_cur, 1'b0, "cleared by err_clr");
    chk("R9", vbus_en_pin, 1'b0, "off right after clear");
    idle(1);
    chk("R9", vbus_en_pin, 1'b1, "retry starts");
    idle(2);

    tag = "R5";
    vbus_drop = 1'b1; idle(1);
    chk("R5", vbus_en_pin, 1'b0, "drop releases pin");
    chk("R5", over_cur, 1'b0, "drop is not an error");
    vbus_drop = 1'b0; bus_req = 1'b0; vbus_st_pin = 1'b0; idle(2);

    tag = "R6";
    base = n_err;
    bus_req = 1'b1; idle(1);
    ticks(WIN - 1);
    chk("R6", over_cur, 1'b0, "no fault before last tick");
    tick_ms = 1'b1; idle(1); tick_ms = 1'b0;
    chk("R6", err_evt, 1'b1, "err_evt on last tick");
    chk("R6", over_cur, 1'b1, "over_cur on timeout");
    chk("R6", vbus_en_pin, 1'b0, "pin released on timeout");
    idle(3);
    chk("R6", (n_err - base) == 1, 1'b1, "exactly one err_evt");
    err_clr = 1'b1; bus_req = 1'b0; idle(1); err_clr = 1'b0; idle(1);

    tag = "R11";
    bus_req = 1'b1; idle(1);
    ticks(WIN - 1);
    id_b = 1'b1; idle(1);
    chk("R11", vbus_en_pin, 1'b0, "B-side forces off");
    id_b = 1'b0; idle(1);
    ticks(WIN - 1);
    chk("R11", over_cur, 1'b0, "window restarted from zero");
    ticks(1);
    chk("R11", over_cur, 1'b1, "timeout after full window");
    id_b = 1'b1; idle(1);
    chk("R11", over_cur, 1'b0, "B-side clears fault");
    id_b = 1'b0; bus_req = 1'b0; idle(2);

    tag = "R7";
    bus_req = 1'b1; idle(1);
    ticks(WIN - 1);
    tick_ms = 1'b1; vbus_st_pin = 1'b1; idle(1); tick_ms = 1'b0;
    chk("R7", up_evt, 1'b1, "valid wins on final tick");
    chk("R7", err_evt, 1'b0, "no error on final tick");
    chk("R7", over_cur, 1'b0, "no fault on final tick");
    bus_req = 1'b0; vbus_st_pin = 1'b0; idle(2);

    tag = "R2";
    rst = 1'b1; en_pol = 1'b1; st_pol = 1'b1; vbus_st_pin = 1'b1; idle(2);
    chk("R2", vbus_en_pin, 1'b1, "inactive-high when active-low");
    rst = 1'b0; idle(1);
    bus_req = 1'b1; idle(1);
    chk("R2", vbus_en_pin, 1'b0, "driven low when on");
    tag = "R3";
    vbus_st_pin = 1'b0; idle(1);
    chk("R3", up_evt, 1'b1, "low status is valid");
    idle(1);
    chk("R3", vbus_en_pin, 1'b0, "stays on");
    vbus_st_pin = 1'b1; idle(1);
    chk("R3", err_evt, 1'b1, "high status is loss");
    chk("R2", vbus_en_pin, 1'b1, "fault releases high");
    idle(2);
    finish_run();
  end
endmodule